// File: doc/BRIEF.md
# I2C Bus Hang Guard

This block sits beside an I2C controller and watches for bus transactions that never finish. A transaction is armed by a start strobe and disarmed by a done strobe. If the done strobe does not arrive within a time limit of 35 ms by default, a sticky timeout flag is raised. The block then takes the SCL and SDA pins away from the normal controller and runs a clock-out sequence. A target that stalled in the middle of a byte with SDA held low receives enough clocks to finish shifting and let go.

The clock-out drives SCL open-drain at 50 kHz by default. It starts with a parked half period with both lines released. Ten low/high SCL pulses follow. Then it makes a STOP: SDA is pulled low while SCL is high, and then released. At the end, the synchronized bus levels decide whether the bus counts as recovered or failed, and the pins are handed back to the normal controller. The sequence runs once on its own after reset, and can also be requested by software-side logic through a request strobe. All timings come from parameters: the system clock frequency, the recovery clock frequency, the timeout in microseconds, the pulse count and the synchronizer depth.

Top module: `i2c_hang_guard`

## Requirements
- R1: While reset is asserted, scl_oe, sda_oe, pin_sel, busy, timeout, recovered and failed are all 0.
- R2: At the first clock edge after reset is released, a recovery sequence starts without any request.
- R3: timeout rises at the LIMIT-th clock edge after the edge that samples txn_start, where LIMIT = (CLK_HZ/1e6)*TIMEOUT_US counted only over edges where busy is low. No timeout occurs if txn_done is sampled at any of edges 1..LIMIT. timeout stays at 1 until the next txn_start is sampled, and it reads 0 after that edge.
- R4: The edge that raises timeout also starts a recovery, so busy is 1 in the same cycle as timeout first reads 1.
- R5: When the block is idle, a recover_req sampled at an edge starts a recovery. busy and pin_sel are 1 for exactly 23*H cycles, where H = CLK_HZ/(2*RECOV_HZ). A recover_req sampled while busy is 1 has no effect.
- R6: Counting cycles p from the starting edge (p = 0), the block drives scl_oe = 0 and sda_oe = 0 for p < H. Then come NUM_PULSES pulses. Each pulse is H cycles with scl_oe = 1 (SCL low), followed by H cycles with scl_oe = 0, and sda_oe stays 0 throughout.
- R7: After the pulses, sda_oe = 1 with scl_oe = 0 for H cycles (SDA low while SCL high). Then both lines are released for H cycles, so a free bus sees exactly one SDA rise while SCL is high.
- R8: At the end of a sequence, recovered is set to 1 if the synchronized SDA and SCL are both high, and failed is set to 1 otherwise. Both flags clear when the next sequence starts.
- R9: While busy is 1, the transaction counter does not advance, which delays a pending timeout by exactly the busy duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Strobe: a bus transaction begins, (re)arms the watchdog |
| txn_done | input | 1 | Strobe: the transaction completed, disarms the watchdog |
| recover_req | input | 1 | Strobe: request a clock-out sequence |
| scl_in | input | 1 | Sampled SCL pin level (asynchronous) |
| sda_in | input | 1 | Sampled SDA pin level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| pin_sel | output | 1 | 1 gives the pins to the recovery engine, 0 to the normal controller |
| busy | output | 1 | Recovery sequence in progress |
| timeout | output | 1 | Sticky: the last armed transaction expired |
| recovered | output | 1 | Last sequence ended with both lines high |
| failed | output | 1 | Last sequence ended with a line still low |

## Verification
The watchdog boundary is swept over every done-strobe offset from 1 to LIMIT+1, plus the case with no done strobe. A counter that is off by one either fires when done arrives on the last legal edge, or misses the expiry edge. A recovery request placed inside an armed window checks that the counter is frozen. A design that kept counting would time out 23*H cycles early. Every cycle of each sequence is compared with the arithmetic pulse pattern, so a wrong half period, a missing or extra tenth pulse, or a STOP with SCL low shows up as a pattern mismatch or a wrong edge count on the modelled bus. A target that releases SDA after seven clocks, one that never releases, and a request issued mid-sequence check that the outcome flags are chosen correctly and that a busy block ignores a second request.

// File: rtl/i2c_hang_pkg.sv
package i2c_hang_pkg;

   // Clock-out sequencer phases, in the order they are visited.
   typedef enum logic [2:0] {
      RC_IDLE     = 3'd0,
      RC_PARK     = 3'd1,
      RC_LOW      = 3'd2,
      RC_HIGH     = 3'd3,
      RC_STOP_SET = 3'd4,
      RC_STOP_REL = 3'd5
   } rc_state_t;

   // Number of half periods one full sequence occupies.
   function automatic int seq_halves(input int pulses);
      return 2 * pulses + 3;
   endfunction

endpackage

// File: rtl/i2c_hang_sync.sv
module i2c_hang_sync #(
   parameter int WIDTH     = 2,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= {WIDTH{RESET_VAL}};
               else        chain_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= {WIDTH{RESET_VAL}};
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_hang_watchdog.sv
module i2c_hang_watchdog #(
   parameter int LIMIT = 4_375_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   input  logic freeze_i,
   output logic expire_o,
   output logic timeout_o
);

   localparam int CW = $clog2(LIMIT + 1);

   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic          to_q;

   // Expiry on the edge where the LIMIT-th counting step would happen.
   assign expire_o = armed_q & ~freeze_i & ~done_i & ~start_i &
                     (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         to_q    <= 1'b0;
      end else if (start_i) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
         to_q    <= 1'b0;
      end else if (done_i) begin
         armed_q <= 1'b0;
      end else if (expire_o) begin
         armed_q <= 1'b0;
         to_q    <= 1'b1;
      end else if (armed_q && !freeze_i) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign timeout_o = to_q;

endmodule

// File: rtl/i2c_hang_clockout.sv
module i2c_hang_clockout
   import i2c_hang_pkg::*;
#(
   parameter int HALF       = 1250,
   parameter int NUM_PULSES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic busy_o,
   output logic scl_oe_o,
   output logic sda_oe_o,
   output logic recovered_o,
   output logic failed_o
);

   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;

   rc_state_t     st_q;
   logic [HW-1:0] tmr_q;
   logic [PW-1:0] pls_q;
   logic          rec_q;
   logic          fail_q;
   logic          half_end;
   logic          last_pulse;
   logic          bus_free;

   assign half_end   = (tmr_q == HW'(HALF - 1));
   assign last_pulse = (pls_q == PW'(NUM_PULSES - 1));
   assign bus_free   = scl_s_i & sda_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RC_IDLE;
         tmr_q  <= '0;
         pls_q  <= '0;
         rec_q  <= 1'b0;
         fail_q <= 1'b0;
      end else if (st_q == RC_IDLE) begin
         if (go_i) begin
            st_q   <= RC_PARK;
            tmr_q  <= '0;
            pls_q  <= '0;
            rec_q  <= 1'b0;
            fail_q <= 1'b0;
         end
      end else if (!half_end) begin
         tmr_q <= tmr_q + 1'b1;
      end else begin
         tmr_q <= '0;
         case (st_q)
            RC_PARK:     st_q <= RC_LOW;
            RC_LOW:      st_q <= RC_HIGH;
            RC_HIGH: begin
               if (last_pulse) begin
                  st_q <= RC_STOP_SET;
               end else begin
                  st_q  <= RC_LOW;
                  pls_q <= pls_q + 1'b1;
               end
            end
            RC_STOP_SET: st_q <= RC_STOP_REL;
            RC_STOP_REL: begin
               st_q   <= RC_IDLE;
               rec_q  <= bus_free;
               fail_q <= ~bus_free;
            end
            default:     st_q <= RC_IDLE;
         endcase
      end
   end

   assign busy_o      = (st_q != RC_IDLE);
   assign scl_oe_o    = (st_q == RC_LOW);
   assign sda_oe_o    = (st_q == RC_STOP_SET);
   assign recovered_o = rec_q;
   assign failed_o    = fail_q;

endmodule

// File: rtl/i2c_hang_guard.sv
module i2c_hang_guard #(
   parameter int CLK_HZ      = 125_000_000,
   parameter int RECOV_HZ    = 50_000,
   parameter int TIMEOUT_US  = 35_000,
   parameter int NUM_PULSES  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic txn_done,
   input  logic recover_req,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic pin_sel,
   output logic busy,
   output logic timeout,
   output logic recovered,
   output logic failed
);

   localparam int HALF      = CLK_HZ / (2 * RECOV_HZ);
   localparam int TO_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;

   generate
      if (CLK_HZ % 1_000_000 != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole number of MHz");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HALF < SYNC_STAGES + 2) begin : g_bad_half
         $error("recovery half period too short for the synchronizer");
      end
      if (NUM_PULSES < 1) begin : g_bad_pulses
         $error("NUM_PULSES must be at least 1");
      end
      if (TO_CYCLES < 2) begin : g_bad_to
         $error("timeout must span at least 2 clock cycles");
      end
   endgenerate

   logic [1:0] line_s;
   logic       expire;
   logic       boot_q;
   logic       go;
   logic       seq_busy;

   i2c_hang_sync #(
      .WIDTH     (2),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_in, sda_in}),
      .q_o   (line_s)
   );

   i2c_hang_watchdog #(
      .LIMIT (TO_CYCLES)
   ) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (txn_start),
      .done_i    (txn_done),
      .freeze_i  (seq_busy),
      .expire_o  (expire),
      .timeout_o (timeout)
   );

   // One-shot request raised by reset, consumed by the first idle cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         boot_q <= 1'b1;
      else if (!seq_busy) boot_q <= 1'b0;
   end

   assign go = boot_q | recover_req | expire;

   i2c_hang_clockout #(
      .HALF       (HALF),
      .NUM_PULSES (NUM_PULSES)
   ) u_clkout (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .scl_s_i     (line_s[1]),
      .sda_s_i     (line_s[0]),
      .busy_o      (seq_busy),
      .scl_oe_o    (scl_oe),
      .sda_oe_o    (sda_oe),
      .recovered_o (recovered),
      .failed_o    (failed)
   );

   assign busy    = seq_busy;
   assign pin_sel = seq_busy;

endmodule

// File: rtl/i2c_hang_guard_chk.sv
module i2c_hang_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_oe,
   input logic sda_oe,
   input logic pin_sel,
   input logic busy,
   input logic timeout,
   input logic recovered,
   input logic failed
);

   // R6 / R7: the two lines are never pulled low together
   a_r7_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_oe && sda_oe));

   // R5: the pins are only driven while the recovery engine owns them
   a_r5_drive_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe || sda_oe) |-> (busy && pin_sel));

   // R8: outcome flags never both set
   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(recovered && failed));

   // R8: a finished sequence reports exactly one outcome
   a_r8_outcome_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (recovered ^ failed));

   // R8: a starting sequence clears the outcome
   a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!recovered && !failed));

   // R4: an expiry launches a recovery at once
   a_r4_timeout_launches: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> busy);

   // R7: SDA is released only while SCL is released (STOP shape)
   a_r7_stop_with_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> (!scl_oe && busy));

   // R6: the sequence starts with both lines released
   a_r6_park_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_hang_guard i2c_hang_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe),
   .pin_sel   (pin_sel),
   .busy      (busy),
   .timeout   (timeout),
   .recovered (recovered),
   .failed    (failed)
);

// File: tb/i2c_hang_guard_bench.sv
module i2c_hang_guard_bench;

   localparam int CLK_HZ  = 1_000_000;
   localparam int REC_HZ  = 50_000;
   localparam int TO_US   = 100;
   localparam int NPULSE  = 10;
   localparam int H       = CLK_HZ / (2 * REC_HZ);
   localparam int LIMIT   = (CLK_HZ / 1_000_000) * TO_US;
   localparam int SEQ_LEN = (2 * NPULSE + 3) * H;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_start = 1'b0;
   logic txn_done = 1'b0;
   logic recover_req = 1'b0;
   logic scl_oe, sda_oe, pin_sel, busy, timeout, recovered, failed;

   int nrun = 0;
   int nfail = 0;
   int cyc = 0;

   // bus and target model
   int falls_total = 0;
   int stop_cnt = 0;
   int tgt_base = 0;
   int tgt_hold = 0;
   logic prev_scl = 1'b1;
   logic prev_sda = 1'b1;
   logic tgt_low, scl_line, sda_line;

   assign tgt_low  = ((falls_total - tgt_base) < tgt_hold);
   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | tgt_low);

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      prev_scl <= scl_line;
      prev_sda <= sda_line;
      if (prev_scl && !scl_line) falls_total <= falls_total + 1;
      if (!prev_sda && sda_line && scl_line && prev_scl) stop_cnt <= stop_cnt + 1;
   end

   i2c_hang_guard #(
      .CLK_HZ      (CLK_HZ),
      .RECOV_HZ    (REC_HZ),
      .TIMEOUT_US  (TO_US),
      .NUM_PULSES  (NPULSE),
      .SYNC_STAGES (2)
   ) u_i2c_hang_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .txn_start   (txn_start),
      .txn_done    (txn_done),
      .recover_req (recover_req),
      .scl_in      (scl_line),
      .sda_in      (sda_line),
      .scl_oe      (scl_oe),
      .sda_oe      (sda_oe),
      .pin_sel     (pin_sel),
      .busy        (busy),
      .timeout     (timeout),
      .recovered   (recovered),
      .failed      (failed)
   );

   task automatic check(input string req, input int act, input int exp);
      nrun++;
      if (act != exp) begin
         nfail++;
         $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at the negedge right after the starting edge (p = 0).
   // Compares every cycle of the sequence with the arithmetic pattern.
   task automatic run_seq(input string req, input int req_at,
                          output int nfalls, output int nstops);
      int f0, s0, bad_p, bad_act, bad_exp;
      f0 = falls_total;
      s0 = stop_cnt;
      bad_p = -1;
      bad_act = 0;
      bad_exp = 0;
      for (int p = 0; p <= SEQ_LEN; p++) begin
         logic e_busy, e_scl, e_sda;
         int act_v, exp_v;
         e_busy = (p < SEQ_LEN);
         e_scl  = (p >= H) && (p < (2 * NPULSE + 1) * H) && (((p - H) / H) % 2 == 0);
         e_sda  = (p >= (2 * NPULSE + 1) * H) && (p < (2 * NPULSE + 2) * H);
         act_v  = {busy, pin_sel, scl_oe, sda_oe};
         exp_v  = {e_busy, e_busy, e_scl, e_sda};
         if (act_v != exp_v && bad_p < 0) begin
            bad_p = p;
            bad_act = act_v;
            bad_exp = exp_v;
         end
         recover_req = (p == req_at);
         if (p < SEQ_LEN) @(negedge clk);
      end
      recover_req = 1'b0;
      nrun++;
      if (bad_p >= 0) begin
         nfail++;
         $display("[TB] FAIL %s pattern at p=%0d actual={busy,sel,scl,sda}=%b expected=%b",
                  req, bad_p, bad_act[3:0], bad_exp[3:0]);
      end
      nfalls = falls_total - f0;
      nstops = stop_cnt - s0;
   endtask

   task automatic pulse_req();
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      recover_req = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   // Arms a transaction; done strobe sampled at edge j (0 = never),
   // recover_req sampled at edge k (0 = never). Returns first edge with timeout.
   task automatic txn_run(input int j, input int k, input int span,
                          output int first, output logic busy_at_to);
      first = -1;
      busy_at_to = 1'b0;
      @(negedge clk);
      txn_start = 1'b1;
      @(negedge clk);
      txn_start = 1'b0;
      check("R3 timeout cleared by txn_start", timeout, 0);
      for (int m = 1; m <= span; m++) begin
         txn_done    = (m == j);
         recover_req = (m == k);
         @(negedge clk);
         if (timeout && first < 0) begin
            first = m;
            busy_at_to = busy;
         end
      end
      txn_done = 1'b0;
      recover_req = 1'b0;
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (190_000) @(posedge clk);
      $display("[TB] FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nrun + 1, nfail + 1);
      $finish;
   end

   initial begin : main
      int nf, ns, first;
      logic bto;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {scl_oe, sda_oe, pin_sel, busy, timeout, recovered, failed}, 0);

      // R2: automatic sequence after reset, free bus
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 busy after reset release", busy, 1);
      run_seq("R2 R6 boot sequence", -1, nf, ns);
      check("R6 boot pulse count", nf, NPULSE);
      check("R7 boot STOP count", ns, 1);
      check("R8 boot recovered", {recovered, failed}, 2);

      // R5 R6 R7 R8: target holding SDA for 7 clocks
      tgt_base = falls_total;
      tgt_hold = 7;
      repeat (3) @(negedge clk);
      check("R5 idle before request", busy, 0);
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      run_seq("R5 R6 stuck-7 sequence", -1, nf, ns);
      check("R6 stuck-7 pulse count", nf, NPULSE);
      check("R7 stuck-7 STOP count", ns, 1);
      check("R8 stuck-7 recovered", {recovered, failed}, 2);

      // R8: target never releases -> failed
      tgt_base = falls_total;
      tgt_hold = 100_000;
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      run_seq("R6 stuck-forever sequence", -1, nf, ns);
      check("R7 stuck-forever no STOP", ns, 0);
      check("R8 stuck-forever failed", {recovered, failed}, 1);
      tgt_hold = 0;

      // R5: request in the middle of a run is ignored; R8 flags cleared on start
      @(negedge clk);
      recover_req = 1'b1;
      @(negedge clk);
      check("R8 flags cleared at start", {recovered, failed}, 0);
      run_seq("R5 request while busy", 5 * H + 3, nf, ns);
      check("R5 single run pulse count", nf, NPULSE);
      repeat (6) @(negedge clk);
      check("R5 request while busy ignored", busy, 0);
      check("R8 recovered after free bus", {recovered, failed}, 2);

      // R3 R4: sweep of done-strobe position, plus no done at all
      for (int j = 0; j <= LIMIT + 1; j++) begin
         int exp_first;
         exp_first = (j == 0 || j > LIMIT) ? LIMIT : -1;
         txn_run(j, 0, LIMIT + 3, first, bto);
         check($sformatf("R3 expiry edge with done at %0d", j), first, exp_first);
         if (exp_first > 0) check("R4 recovery with timeout", bto, 1);
      end

      // R9: recovery inside an armed window freezes the counter
      txn_run(0, 20, LIMIT + SEQ_LEN + 5, first, bto);
      check("R9 expiry delayed by busy time", first, LIMIT + SEQ_LEN);
      check("R4 recovery with delayed timeout", bto, 1);

      // R3: sticky flag holds until next start
      repeat (20) @(negedge clk);
      check("R3 timeout sticky", timeout, 1);
      @(negedge clk);
      txn_start = 1'b1;
      @(negedge clk);
      txn_start = 1'b0;
      txn_done = 1'b1;
      check("R3 timeout cleared", timeout, 0);
      @(negedge clk);
      txn_done = 1'b0;
      check("R5 pins returned", {pin_sel, scl_oe, sda_oe}, 0);

      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
   end

endmodule